// File: doc/BRIEF.md
# Byte-Wide Erasable Memory Device Model

This block is a synthesizable, clock-based model of a byte-wide memory that can be erased to all ones and then programmed, one byte at a time, by clearing bits. It stands in for the real part in two roles. It can be the device under test for a programming sequencer, or it can be a boot store inside a simulated system. The control inputs are an active-low chip select, which also serves as the program strobe, and an active-low output enable. Two digital flags stand in for analog levels: one for a raised programming supply and one for a high voltage on the signature address pin. From these inputs the block decodes seven modes: standby, output disable, read, signature, program, verify and inhibit.

A program pulse is timed by a three-state sequencer. The states are `PG_IDLE`, `PG_PULSE` and `PG_COMMIT`. The sequencer moves from `PG_IDLE` to `PG_PULSE` on the first clock edge that sees program mode, and stays in `PG_PULSE` while program mode holds. When the strobe ends, it goes to `PG_COMMIT` if the pulse was long enough, and otherwise back to `PG_IDLE`. `PG_COMMIT` always returns to `PG_IDLE` after one cycle. An erase request sends the sequencer from any state to `PG_IDLE`. The write itself happens in the `PG_COMMIT` cycle: the stored byte is ANDed with the byte captured when the pulse began.

Output data follows access delays counted in clock cycles. Until a delay has elapsed, the data bus carries a fixed invalid marker.

Top module: `byte_rom_model`

## Requirements
- R1: After reset every byte of the array reads 8'hFF, and with the chip select high the outputs are not driven (`dout_oe`=0, `dout_valid`=0, `dout`=MARK, default 8'hEE).
- R2: With the supply flag low, the signature flag low, and chip select and output enable both low, `dout_oe`=1 and the byte stored at `addr` is presented once the access delays of R11 and R12 have passed.
- R3: With the supply flag low and the chip select high, `dout_oe`=0 whatever the output enable level.
- R4: With the supply flag low, the chip select low and the output enable high, `dout_oe`=0.
- R5: With the supply flag high, the output enable high and the chip select held low for at least MIN_PULSE rising edges (default 4), the byte at the captured address becomes old AND `din`. The new value is in place two edges after the chip select rises.
- R6: A program pulse of fewer than MIN_PULSE rising edges leaves the stored byte unchanged.
- R7: With the supply flag high and the output enable low, the stored byte is driven whatever the chip select level. In this mode validity waits only on the address and output enable delays.
- R8: With the supply flag high and both controls high, `dout_oe`=0 and no byte is written, whatever `din` holds.
- R9: One cycle of `erase` high sets every byte of the array to 8'hFF.
- R10: With the signature flag high, the supply flag low and both controls low, the data is 8'h8F when `addr[0]`=0 and 8'h08 when `addr[0]`=1, independent of the array contents.
- R11: `dout_valid` rises at the ACC_CYC-th rising edge (default 6) after the last address change or chip select fall. Before that, `dout` shows MARK.
- R12: `dout_valid` also needs OE_CYC rising edges (default 2) since the output enable fell. An output enable that falls ACC_CYC−OE_CYC edges after the chip select does not delay data past edge ACC_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Byte address |
| chip_en_n | input | 1 | Active-low chip select and program strobe |
| out_en_n | input | 1 | Active-low output enable |
| prog_hv | input | 1 | Programming supply raised |
| sig_hv | input | 1 | High voltage on the signature address pin |
| erase | input | 1 | Erase request, one cycle |
| din | input | 8 | Byte to program |
| dout | output | 8 | Data bus value |
| dout_oe | output | 1 | Data bus driven (low means high impedance) |
| dout_valid | output | 1 | Data on `dout` has met its access delays |

## Verification
If the program sequencer is left in the wrong state, the effect shows at the ports one or two edges after the strobe rises. A short pulse that still commits would clear bits, and a long pulse that never commits would leave a stale byte. Either error appears at the next verify read, about ACC_CYC edges later. If an age counter starts from the wrong count, `dout_valid` rises one edge early or late. That error is visible at the first sample around the delay boundary. A decode error in the mode logic shows up as a wrong `dout_oe` at the very next sample.

// File: rtl/rom_model_pkg.sv
package rom_model_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_OUTDIS,
        MD_READ,
        MD_SIGNATURE,
        MD_PROGRAM,
        MD_VERIFY,
        MD_INHIBIT
    } rom_mode_e;

    typedef enum logic [1:0] {
        PG_IDLE,
        PG_PULSE,
        PG_COMMIT
    } pgm_state_e;

endpackage

// File: rtl/rom_mode_dec.sv
module rom_mode_dec
    import rom_model_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      prog_hv,
    input  logic      sig_hv,
    output rom_mode_e mode,
    output logic      drive,
    output logic      need_ce
);

    always_comb begin
        if (!prog_hv) begin
            if (ce_n)        mode = MD_STANDBY;
            else if (oe_n)   mode = MD_OUTDIS;
            else if (sig_hv) mode = MD_SIGNATURE;
            else             mode = MD_READ;
        end else begin
            if (!oe_n)       mode = MD_VERIFY;
            else if (!ce_n)  mode = MD_PROGRAM;
            else             mode = MD_INHIBIT;
        end
    end

    always_comb begin
        unique case (mode)
            MD_READ, MD_SIGNATURE: begin drive = 1'b1; need_ce = 1'b1; end
            MD_VERIFY:             begin drive = 1'b1; need_ce = 1'b0; end
            default:               begin drive = 1'b0; need_ce = 1'b1; end
        endcase
    end

endmodule

// File: rtl/rom_access_timer.sv
module rom_access_timer #(
    parameter int AW      = 8,
    parameter int ACC_CYC = 6,
    parameter int OE_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          check_ce,
    output logic          ready
);

    localparam int CW = $clog2(ACC_CYC + 2);
    localparam logic [CW-1:0] LIM    = CW'(ACC_CYC);
    localparam logic [CW-1:0] OE_LIM = CW'(OE_CYC);

    logic [AW-1:0] addr_q;
    logic [CW-1:0] addr_age, ce_age, oe_age;
    logic          addr_chg;

    function automatic logic [CW-1:0] bump(input logic [CW-1:0] v);
        return (v >= LIM) ? LIM : v + 1'b1;
    endfunction

    assign addr_chg = (addr != addr_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            addr_age <= '0;
            ce_age   <= '0;
            oe_age   <= '0;
        end else begin
            addr_q   <= addr;
            addr_age <= addr_chg ? CW'(1) : bump(addr_age);
            ce_age   <= ce_n ? '0 : bump(ce_age);
            oe_age   <= oe_n ? '0 : bump(oe_age);
        end
    end

    always_comb begin
        ready = !addr_chg && (addr_age >= LIM) && (oe_age >= OE_LIM)
                && (!check_ce || (ce_age >= LIM));
    end

endmodule

// File: rtl/rom_cell_array.sv
module rom_cell_array
    import rom_model_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_en) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/byte_rom_model.sv
module byte_rom_model
    import rom_model_pkg::*;
#(
    parameter int                AW        = 8,
    parameter int                ACC_CYC   = 6,
    parameter int                OE_CYC    = 2,
    parameter int                MIN_PULSE = 4,
    parameter logic [BYTE_W-1:0] MARK      = 8'hEE,
    parameter logic [BYTE_W-1:0] MFR_CODE  = 8'h8F,
    parameter logic [BYTE_W-1:0] DEV_CODE  = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              chip_en_n,
    input  logic              out_en_n,
    input  logic              prog_hv,
    input  logic              sig_hv,
    input  logic              erase,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_oe,
    output logic              dout_valid
);

    localparam int PCW = $clog2(MIN_PULSE + 2);
    localparam logic [PCW-1:0] PLIM = PCW'(MIN_PULSE);

    rom_mode_e         mode;
    logic              drive, need_ce, ready, wr_en;
    pgm_state_e        state, state_nx;
    logic [AW-1:0]     cap_addr;
    logic [BYTE_W-1:0] cap_data, rd_data;
    logic [PCW-1:0]    pw_cnt;

    rom_mode_dec u_dec (
        .ce_n    (chip_en_n),
        .oe_n    (out_en_n),
        .prog_hv (prog_hv),
        .sig_hv  (sig_hv),
        .mode    (mode),
        .drive   (drive),
        .need_ce (need_ce)
    );

    rom_access_timer #(.AW(AW), .ACC_CYC(ACC_CYC), .OE_CYC(OE_CYC)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .ce_n     (chip_en_n),
        .oe_n     (out_en_n),
        .check_ce (need_ce),
        .ready    (ready)
    );

    rom_cell_array #(.AW(AW)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .erase   (erase),
        .wr_en   (wr_en),
        .wr_addr (cap_addr),
        .wr_data (cap_data),
        .rd_addr (addr),
        .rd_data (rd_data)
    );

    // program pulse sequencer: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PG_IDLE;
        else        state <= state_nx;
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        if (erase) begin
            state_nx = PG_IDLE;
        end else begin
            unique case (state)
                PG_IDLE:   state_nx = (mode == MD_PROGRAM) ? PG_PULSE : PG_IDLE;
                PG_PULSE: begin
                    if (mode == MD_PROGRAM)  state_nx = PG_PULSE;
                    else if (pw_cnt >= PLIM) state_nx = PG_COMMIT;
                    else                     state_nx = PG_IDLE;
                end
                PG_COMMIT: state_nx = PG_IDLE;
                default:   state_nx = PG_IDLE;
            endcase
        end
    end

    // pulse width and capture of address and data at pulse start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '1;
            pw_cnt   <= '0;
        end else if (state == PG_IDLE && mode == MD_PROGRAM) begin
            cap_addr <= addr;
            cap_data <= din;
            pw_cnt   <= PCW'(1);
        end else if (state == PG_PULSE && mode == MD_PROGRAM) begin
            pw_cnt   <= (pw_cnt >= PLIM) ? PLIM : pw_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        wr_en      = (state == PG_COMMIT);
        dout_oe    = drive;
        dout_valid = drive && ready;
        if (!dout_valid)                dout = MARK;
        else if (mode == MD_SIGNATURE)  dout = addr[0] ? DEV_CODE : MFR_CODE;
        else                            dout = rd_data;
    end

endmodule

// File: rtl/byte_rom_model_chk.sv
module byte_rom_model_chk #(
    parameter int         AW       = 8,
    parameter int         OE_CYC   = 2,
    parameter logic [7:0] MARK     = 8'hEE,
    parameter logic [7:0] MFR_CODE = 8'h8F,
    parameter logic [7:0] DEV_CODE = 8'h08
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          chip_en_n,
    input logic          out_en_n,
    input logic          prog_hv,
    input logic          sig_hv,
    input logic [7:0]    dout,
    input logic          dout_oe,
    input logic          dout_valid
);

    a_r3_standby_float: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_hv && chip_en_n) |-> !dout_oe);

    a_r4_outdis_float: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_hv && !chip_en_n && out_en_n) |-> !dout_oe);

    a_r7_verify_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_hv && !out_en_n) |-> dout_oe);

    a_r8_inhibit_float: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_hv && chip_en_n && out_en_n) |-> !dout_oe);

    a_r10_sig_code: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_hv && sig_hv && !chip_en_n && !out_en_n && dout_valid)
        |-> (dout == (addr[0] ? DEV_CODE : MFR_CODE)));

    a_r11_marker_when_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_valid |-> (dout == MARK));

    a_r11_valid_needs_stable_addr: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> $stable(addr));

    a_r12_oe_fall_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ((OE_CYC > 0) && $fell(out_en_n)) |-> !dout_valid);

endmodule

bind byte_rom_model byte_rom_model_chk #(
    .AW(AW), .OE_CYC(OE_CYC), .MARK(MARK), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .chip_en_n  (chip_en_n),
    .out_en_n   (out_en_n),
    .prog_hv    (prog_hv),
    .sig_hv     (sig_hv),
    .dout       (dout),
    .dout_oe    (dout_oe),
    .dout_valid (dout_valid)
);

// File: tb/tb_byte_rom_model.sv
module tb_byte_rom_model;

    localparam int         CLK_P = 10;
    localparam int         AW    = 8;
    localparam int         ACC   = 6;
    localparam int         OEC   = 2;
    localparam int         MINP  = 4;
    localparam logic [7:0] MARK  = 8'hEE;

    typedef struct {
        logic [7:0] data;
        logic       oe;
        logic       valid;
        string      req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          chip_en_n = 1'b1, out_en_n = 1'b1;
    logic          prog_hv = 1'b0, sig_hv = 1'b0, erase = 1'b0;
    logic [7:0]    din = '1;
    logic [7:0]    dout;
    logic          dout_oe, dout_valid;

    int   checks = 0, failures = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];
    event smp_ev;

    always #(CLK_P/2) clk = ~clk;

    byte_rom_model #(.AW(AW), .ACC_CYC(ACC), .OE_CYC(OEC), .MIN_PULSE(MINP), .MARK(MARK)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
        .prog_hv(prog_hv), .sig_hv(sig_hv), .erase(erase), .din(din),
        .dout(dout), .dout_oe(dout_oe), .dout_valid(dout_valid)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(smp_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (dout !== e.data || dout_oe !== e.oe || dout_valid !== e.valid) begin
                    failures++;
                    $display("FAIL %s: dout=%h oe=%b valid=%b expected dout=%h oe=%b valid=%b",
                             e.req, dout, dout_oe, dout_valid, e.data, e.oe, e.valid);
                end
            end
        end
    end

    task automatic push(input logic [7:0] d, input logic oe, input logic v, input string req);
        exp_t e;
        e.data = d; e.oe = oe; e.valid = v; e.req = req;
        exp_q.push_back(e);
        -> smp_ev;
    endtask

    // sample point: 2 time units after the next rising edge
    task automatic sample_after_edge(input logic [7:0] d, input logic oe, input logic v,
                                     input string req);
        @(posedge clk); #2;
        push(d, oe, v, req);
    endtask

    // read or verify: forces an address change and fresh controls, checks the edge boundary
    task automatic read_check(input logic [AW-1:0] a, input logic [7:0] exp_d,
                              input logic hv, input logic sig, input string req);
        @(negedge clk);
        prog_hv = hv; sig_hv = sig; chip_en_n = 1'b1; out_en_n = 1'b1; addr = a ^ 1'b1;
        @(negedge clk);
        chip_en_n = 1'b0; out_en_n = 1'b0; addr = a;
        repeat (ACC - 1) @(posedge clk);
        #2 push(MARK, 1'b1, 1'b0, {req, " R11 early"});
        sample_after_edge(exp_d, 1'b1, 1'b1, req);
        @(negedge clk);
        chip_en_n = 1'b1; out_en_n = 1'b1; sig_hv = 1'b0; prog_hv = 1'b0;
    endtask

    task automatic prog_byte(input logic [AW-1:0] a, input logic [7:0] d, input int edges);
        @(negedge clk);
        prog_hv = 1'b1; chip_en_n = 1'b1; out_en_n = 1'b1; addr = a; din = d;
        @(negedge clk);
        chip_en_n = 1'b0;
        repeat (edges) @(posedge clk);
        @(negedge clk);
        chip_en_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        prog_hv = 1'b0; din = '1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state, R3 standby
        sample_after_edge(MARK, 1'b0, 1'b0, "R1 reset outputs");
        read_check(8'd5, 8'hFF, 1'b0, 1'b0, "R1 R2 erased read");

        // R5 program, R7 verify
        prog_byte(8'd5, 8'h3C, MINP);
        read_check(8'd5, 8'h3C, 1'b1, 1'b0, "R5 R7 verify after program");
        read_check(8'd5, 8'h3C, 1'b0, 1'b0, "R2 read programmed byte");
        prog_byte(8'd5, 8'hF0, MINP + 3);
        read_check(8'd5, 8'h30, 1'b1, 1'b0, "R5 AND with old value");

        // R6 short pulse
        prog_byte(8'd5, 8'h00, MINP - 1);
        read_check(8'd5, 8'h30, 1'b1, 1'b0, "R6 short pulse no write");

        prog_byte(8'd9, 8'hA5, MINP);
        read_check(8'd9, 8'hA5, 1'b0, 1'b0, "R5 second address");
        read_check(8'd5, 8'h30, 1'b0, 1'b0, "R5 neighbour unchanged");

        // R8 inhibit
        @(negedge clk);
        prog_hv = 1'b1; chip_en_n = 1'b1; out_en_n = 1'b1; addr = 8'd5; din = 8'h00;
        repeat (MINP + 2) @(posedge clk);
        #2 push(MARK, 1'b0, 1'b0, "R8 inhibit floats");
        read_check(8'd5, 8'h30, 1'b1, 1'b0, "R8 inhibit no write");

        // R10 signature codes, independent of contents
        read_check(8'd4, 8'h8F, 1'b0, 1'b1, "R10 manufacturer code");
        read_check(8'd5, 8'h08, 1'b0, 1'b1, "R10 device code");

        // R12 late output enable
        @(negedge clk);
        prog_hv = 1'b0; chip_en_n = 1'b1; out_en_n = 1'b1; addr = 8'd9;
        @(negedge clk);
        chip_en_n = 1'b0; addr = 8'd5;
        repeat (ACC - OEC) @(posedge clk);
        @(negedge clk) out_en_n = 1'b0;
        repeat (OEC - 1) @(posedge clk);
        #2 push(MARK, 1'b1, 1'b0, "R12 late oe not yet");
        sample_after_edge(8'h30, 1'b1, 1'b1, "R12 late oe valid at access time");

        // R4 output disable, then R12 oe-only delay
        @(negedge clk) out_en_n = 1'b1;
        sample_after_edge(MARK, 1'b0, 1'b0, "R4 output disable");
        @(negedge clk) out_en_n = 1'b0;
        repeat (OEC - 1) @(posedge clk);
        #2 push(MARK, 1'b1, 1'b0, "R12 oe delay early");
        sample_after_edge(8'h30, 1'b1, 1'b1, "R12 oe delay met");

        // R3 standby with output enable low
        @(negedge clk) chip_en_n = 1'b1;
        sample_after_edge(MARK, 1'b0, 1'b0, "R3 standby ignores oe");

        // R9 erase
        @(negedge clk) begin out_en_n = 1'b1; erase = 1'b1; end
        @(negedge clk) erase = 1'b0;
        read_check(8'd5, 8'hFF, 1'b0, 1'b0, "R9 erased addr 5");
        read_check(8'd9, 8'hFF, 1'b1, 1'b0, "R9 erased addr 9");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule